// File: doc/BRIEF.md
# Fetch Thread Picker

This block decides, in each selection slot, which hardware thread the first pipeline stage serves. It holds an ordered priority list of thread numbers. Each thread supplies a three-bit status code, and an active mask says which threads exist at the moment. The choice is made combinationally from the current list. When the consumer takes the choice by raising the select strobe, the chosen thread is pulled out of its slot and placed at the tail of the list. Threads that have waited longest therefore come first.

When exactly one thread is active, the list plays no part. That thread is chosen if its status allows, and the list is not rotated. If nothing is eligible, the valid flag stays low. The consumer raises the strobe once per instruction it wants to take in a cycle. It stops when its width is used up or when the valid flag drops.

Top module: `threadPick`

## Requirements
- R1: After reset the priority list holds thread numbers 0,1,2,3 from head to tail. With all four threads active and Running, the pick is thread 0.
- R2: Status codes are 0 Running, 1 Idle, 2 Unblocking, 3 Blocked and 4 Squashing. Only codes 0, 1 and 2 make a thread eligible. Codes 3 to 7 never do.
- R3: With two or more threads active, the pick is the first eligible thread found when the list is scanned from head to tail.
- R4: With two or more threads active, a clock edge that sees the strobe high and a valid pick removes the picked thread from its slot. The entries behind it move one slot toward the head, and the picked thread goes into the tail slot.
- R5: A clock edge with the strobe low, or with no valid pick, leaves the list unchanged.
- R6: With exactly one thread active, that thread is picked when its status is eligible, and the list does not rotate even when the strobe is high. An ineligible sole thread gives no valid pick.
- R7: When no thread is active, or no active thread is eligible, the valid output is 0 and the thread output is 0.
- R8: A thread whose active-mask bit is 0 is never picked, whatever its status.
- R9: The pick follows changes on the status and active-mask inputs in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| threadStatus | input | 4x3 | Status code per thread; thread t in bits [3t+2:3t] |
| activeMask | input | 4 | Bit t set when thread t is active |
| selStrobe | input | 1 | Consumer takes the current pick |
| selId | output | 2 | Chosen thread number |
| selValid | output | 1 | The pick is usable |

## Verification
The pick and its valid flag are combinational. The bench drives inputs on the falling edge and samples one nanosecond later, in the same cycle, with no register in between. A rotation shows up only in the pick of the next cycle, after one rising edge. So every check on list order is made on the falling edge that follows the strobed edge. The bench keeps its own copy of the list and updates it at that same edge to compute what it expects.

// File: rtl/threadPick_pkg.sv
`timescale 1ns/1ps
package threadPick_pkg;
  localparam int NumThreads = 4;
  localparam int ThreadIdW  = $clog2(NumThreads);
  localparam int StatusW    = 3;

  typedef enum logic [StatusW-1:0] {
    ST_RUN      = 3'd0,
    ST_IDLE     = 3'd1,
    ST_UNBLOCK  = 3'd2,
    ST_BLOCKED  = 3'd3,
    ST_SQUASH   = 3'd4
  } thrStatus_e;

  // strobes from control to the list datapath
  typedef struct packed {
    logic                 rotate;
    logic [ThreadIdW-1:0] pos;
    logic [ThreadIdW-1:0] winner;
  } listCtl_t;
endpackage

// File: rtl/threadPick_ctrl.sv
`timescale 1ns/1ps
module threadPick_ctrl
  import threadPick_pkg::*;
#(
  parameter int N    = NumThreads,
  parameter int IdW  = ThreadIdW,
  parameter int StW  = StatusW
) (
  input  logic [N-1:0][StW-1:0] threadStatus,
  input  logic [N-1:0]          activeMask,
  input  logic                  selStrobe,
  input  logic [N-1:0][IdW-1:0] priList,
  output logic [IdW-1:0]        selId,
  output logic                  selValid,
  output listCtl_t              ctl
);
  localparam int CntW = $clog2(N + 1);

  logic [N-1:0]    eligible;
  logic [CntW-1:0] activeCnt;
  logic            multiFound;
  logic [IdW-1:0]  multiPos;
  logic [IdW-1:0]  multiId;
  logic [IdW-1:0]  soleId;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_elig
      assign eligible[g] = activeMask[g] &&
        ((threadStatus[g] == ST_RUN) || (threadStatus[g] == ST_IDLE) ||
         (threadStatus[g] == ST_UNBLOCK));
    end
  endgenerate

  always_comb begin
    activeCnt = '0;
    soleId    = '0;
    for (int t = 0; t < N; t++) begin
      if (activeMask[t]) begin
        activeCnt = activeCnt + CntW'(1);
        soleId    = IdW'(t);
      end
    end
  end

  // scan list from head for first eligible entry
  always_comb begin
    multiFound = 1'b0;
    multiPos   = '0;
    multiId    = '0;
    for (int i = 0; i < N; i++) begin
      if (!multiFound && eligible[priList[i]]) begin
        multiFound = 1'b1;
        multiPos   = IdW'(i);
        multiId    = priList[i];
      end
    end
  end

  always_comb begin
    selValid   = 1'b0;
    selId      = '0;
    ctl.rotate = 1'b0;
    ctl.pos    = multiPos;
    ctl.winner = multiId;
    if (activeCnt > CntW'(1)) begin
      selValid   = multiFound;
      selId      = multiFound ? multiId : '0;
      ctl.rotate = selStrobe && multiFound;
    end else if (activeCnt == CntW'(1)) begin
      selValid = eligible[soleId];
      selId    = eligible[soleId] ? soleId : '0;
    end
  end
endmodule

// File: rtl/threadPick_list.sv
`timescale 1ns/1ps
module threadPick_list
  import threadPick_pkg::*;
#(
  parameter int N   = NumThreads,
  parameter int IdW = ThreadIdW
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  listCtl_t              ctl,
  output logic [N-1:0][IdW-1:0] priList
);
  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_slot
      logic [IdW-1:0] nextVal;
      if (g == N - 1) begin : g_tail
        assign nextVal = ctl.winner;
      end else begin : g_body
        assign nextVal = (IdW'(g) >= ctl.pos) ? priList[g+1] : priList[g];
      end
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) priList[g] <= IdW'(g);
        else if (ctl.rotate) priList[g] <= nextVal;
      end
    end
  endgenerate
endmodule

// File: rtl/threadPick.sv
`timescale 1ns/1ps
module threadPick
  import threadPick_pkg::*;
#(
  parameter int N   = NumThreads,
  parameter int IdW = ThreadIdW,
  parameter int StW = StatusW
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [N-1:0][StW-1:0] threadStatus,
  input  logic [N-1:0]          activeMask,
  input  logic                  selStrobe,
  output logic [IdW-1:0]        selId,
  output logic                  selValid
);
  listCtl_t              ctl;
  logic [N-1:0][IdW-1:0] priList;

  threadPick_ctrl #(.N(N), .IdW(IdW), .StW(StW)) uCtrl (
    .threadStatus(threadStatus),
    .activeMask  (activeMask),
    .selStrobe   (selStrobe),
    .priList     (priList),
    .selId       (selId),
    .selValid    (selValid),
    .ctl         (ctl)
  );

  threadPick_list #(.N(N), .IdW(IdW)) uList (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .priList(priList)
  );
endmodule

// File: rtl/threadPick_chk.sv
`timescale 1ns/1ps
module threadPick_chk #(
  parameter int N   = 4,
  parameter int IdW = 2,
  parameter int StW = 3
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [N-1:0][StW-1:0] threadStatus,
  input logic [N-1:0]          activeMask,
  input logic                  selStrobe,
  input logic [IdW-1:0]        selId,
  input logic                  selValid,
  input logic [N-1:0][IdW-1:0] priList
);
  // R7
  invalid_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !selValid |-> selId == '0);

  // R2
  eligible_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    selValid |-> threadStatus[selId] <= StW'(2));

  // R8
  active_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    selValid |-> activeMask[selId]);

  // R5
  hold_list_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(selStrobe && selValid) |=> $stable(priList));

  // R6
  sole_norotate_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(activeMask) == 1) |=> $stable(priList));

  // R4
  tail_winner_chk: assert property (@(posedge clk) disable iff (!rstN)
    (selStrobe && selValid && $countones(activeMask) > 1)
      |=> priList[N-1] == $past(selId));
endmodule

bind threadPick threadPick_chk #(.N(N), .IdW(IdW), .StW(StW)) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .threadStatus(threadStatus),
  .activeMask  (activeMask),
  .selStrobe   (selStrobe),
  .selId       (selId),
  .selValid    (selValid),
  .priList     (priList)
);

// File: tb/threadPick_test.sv
`timescale 1ns/1ps
module threadPick_test;
  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [3:0][2:0] threadStatus = '0;
  logic [3:0]      activeMask = '0;
  logic            selStrobe = 1'b0;
  logic [1:0]      selId;
  logic            selValid;

  int checks = 0;
  int fails  = 0;
  int refList [4];

  always #2 clk = ~clk;

  threadPick uut (
    .clk(clk), .rstN(rstN), .threadStatus(threadStatus),
    .activeMask(activeMask), .selStrobe(selStrobe),
    .selId(selId), .selValid(selValid)
  );

  function automatic bit okStat(input logic [2:0] s);
    return s <= 3'd2;
  endfunction

  // expected pick from the bench's own list, per R2,R3,R6,R7,R8
  task automatic refPick(output bit v, output int id, output int pos);
    int cnt = 0;
    int sole = 0;
    v = 0; id = 0; pos = 0;
    for (int t = 0; t < 4; t++) if (activeMask[t]) begin cnt++; sole = t; end
    if (cnt > 1) begin
      for (int i = 0; i < 4; i++)
        if (!v && activeMask[refList[i]] && okStat(threadStatus[refList[i]])) begin
          v = 1; id = refList[i]; pos = i;
        end
    end else if (cnt == 1 && okStat(threadStatus[sole])) begin
      v = 1; id = sole;
    end
  endtask

  // drive at negedge, sample 1ns later, optionally strobe through posedge
  task automatic step(input logic [3:0][2:0] st, input logic [3:0] m,
                      input bit strobe, input string req);
    bit v; int id; int pos; int cnt;
    @(negedge clk);
    threadStatus = st; activeMask = m; selStrobe = strobe;
    #1;
    refPick(v, id, pos);
    checks++;
    if (selValid !== v || int'(selId) !== id) begin
      fails++;
      $display("FAIL %s: got valid=%0d id=%0d expected valid=%0d id=%0d",
               req, selValid, selId, v, id);
    end
    cnt = $countones(m);
    @(posedge clk);
    if (strobe && v && cnt > 1) begin
      for (int i = pos; i < 3; i++) refList[i] = refList[i+1];
      refList[3] = id;
    end
    #0.5 selStrobe = 1'b0;
  endtask

  task automatic expectFixed(input bit v, input int id, input string req);
    checks++;
    if (selValid !== v || int'(selId) !== id) begin
      fails++;
      $display("FAIL %s: got valid=%0d id=%0d expected valid=%0d id=%0d",
               req, selValid, selId, v, id);
    end
  endtask

  localparam logic [3:0][2:0] AllRun = '0;

  task automatic testReset();
    step(AllRun, 4'b1111, 0, "R1");
    @(negedge clk); #1 expectFixed(1, 0, "R1 reset head");
  endtask

  task automatic testRotate();
    for (int k = 0; k < 5; k++) step(AllRun, 4'b1111, 1, "R4 rotate");
    @(negedge clk); #1 expectFixed(1, 1, "R4 after five takes");
  endtask

  task automatic testHold();
    for (int k = 0; k < 3; k++) step(AllRun, 4'b1111, 0, "R5 no strobe");
    @(negedge clk); #1 expectFixed(1, 1, "R5 list held");
  endtask

  task automatic testStatus();
    // t3 Unblocking, t2 Idle, t1 Squashing, t0 Blocked
    step({3'd2, 3'd1, 3'd4, 3'd3}, 4'b1111, 1, "R2 R3 mixed status");
    step({3'd3, 3'd1, 3'd0, 3'd4}, 4'b1111, 1, "R3 first eligible");
    step({3'd7, 3'd6, 3'd5, 3'd3}, 4'b1111, 1, "R2 R7 codes 3..7");
    @(negedge clk); threadStatus = {3'd7, 3'd6, 3'd5, 3'd3}; #1
    expectFixed(0, 0, "R2 no eligible code");
  endtask

  task automatic testSkip();
    step(AllRun, 4'b1010, 1, "R8 skip inactive");
    step(AllRun, 4'b1010, 1, "R8 skip inactive");
    step({3'd0, 3'd3, 3'd0, 3'd0}, 4'b0110, 1, "R8 inactive eligible");
  endtask

  task automatic testSole();
    int headBefore;
    bit v; int pos;
    activeMask = 4'b1111; threadStatus = AllRun;
    refPick(v, headBefore, pos);
    step(AllRun, 4'b0100, 1, "R6 sole eligible");
    step({3'd0, 3'd3, 3'd0, 3'd0}, 4'b0100, 1, "R6 sole blocked");
    @(negedge clk); threadStatus = AllRun; activeMask = 4'b1111; #1
    expectFixed(1, headBefore, "R6 list not rotated");
  endtask

  task automatic testNone();
    step(AllRun, 4'b0000, 1, "R7 none active");
    @(negedge clk); threadStatus = AllRun; activeMask = 4'b0000; #1
    expectFixed(0, 0, "R7 none active");
  endtask

  task automatic testComb();
    bit v; int id; int pos;
    @(negedge clk);
    threadStatus = AllRun; activeMask = 4'b1111; #1
    activeMask = 4'b1000; #0.5
    expectFixed(1, 3, "R9 same-cycle mask change");
    threadStatus = {3'd4, 3'd0, 3'd0, 3'd0}; #0.5
    expectFixed(0, 0, "R9 same-cycle status change");
    activeMask = 4'b1111; threadStatus = AllRun; #0.5
    refPick(v, id, pos);
    expectFixed(v, id, "R9 restore");
  endtask

  bit done = 0;
  initial begin
    for (int i = 0; i < 4; i++) refList[i] = i;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    testReset();
    testRotate();
    testHold();
    testStatus();
    testSkip();
    testSole();
    testNone();
    testComb();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #40000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule